// File: doc/BRIEF.md
# Linked-Descriptor DMA Sequencer

This block is the engine of one DMA channel. It moves 128-bit quadwords from memory to a peripheral FIFO and follows a chain of 128-bit descriptors stored in memory. A start pulse loads the channel's configuration: tag address, data address, quadword count, and three flags (chain mode, tag forwarding, tag interrupt enable). The channel then stays busy until it finishes or faults.

While the count is non-zero, the block reads the quadword at the data address and offers it on the output port. Each beat the FIFO accepts moves the data address up by 16 and lowers the count by one. When the count reaches zero and no end is pending, the block reads the next descriptor. It can first push the descriptor's upper 64 bits to the FIFO. It then loads the new count and data address, and moves the tag address according to the descriptor's ID. When the count reaches zero with an end pending, the channel stops and pulses `done`. In normal mode an end is pending from the start, so the block makes one plain block transfer.

Descriptor layout:

| Bits | Field |
|------|-------|
| [15:0] | quadword count |
| [27:16] | spare control bits |
| [30:28] | ID |
| [31] | IRQ |
| [63:32] | address field |
| [127:64] | payload, used for forwarding |

ID codes:

| ID | Code |
|----|------|
| REFE | 0 |
| CNT | 1 |
| NEXT | 2 |
| REF | 3 |
| END | 7 |

Top module: `chain_dma_seq`

## Requirements
- R1: After reset the outputs `busy`, `done`, `err`, `outValid` and `memReq` are all 0.
- R2: In normal mode (`cfgChain`=0), a start with count N sends N quadwords. They are read from `cfgDataAddr`, `cfgDataAddr`+16, and so on up to N-1 steps. Then exactly one `done` pulse follows and `busy` drops. With N=0 nothing is sent and `done` still pulses.
- R3: A data beat holds `outValid` and `outData` steady while `outReady` is 0. The data address and the count change only when a beat is accepted, by +16 and -1.
- R4: Applying a descriptor loads `curCount` from bits [15:0] and `ctrlHi` from bits [31:16].
- R5: For ID REFE (0), the data address becomes the address field, the tag address advances by 16, and the chain ends after that data.
- R6: For ID CNT (1), the data address becomes tag address+16, and the next tag address becomes that data address + count×16.
- R7: For ID NEXT (2), the data address becomes tag address+16, and the next tag address becomes the address field.
- R8: For ID REF (3), the data address becomes the address field, the tag address advances by 16, and the chain continues.
- R9: For ID END (7), the data address becomes tag address+16, and the chain ends after that data.
- R10: A descriptor with IRQ (bit 31) set ends the chain after its data only when `cfgIrqEn` is 1. With `cfgIrqEn`=0 the chain continues.
- R11: With `cfgTagFwd`=1, each descriptor's bits [127:64] are offered before its data. They appear zero-extended on `outData` with `outIsTag`=1. If the offer is refused in its single cycle, the descriptor is read from memory again.
- R12: A descriptor with any other ID (4, 5, 6) sets `err`, drops `busy` and gives no `done` pulse. A new start clears `err`.
- R13: `done` is a one-cycle pulse and is only high while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load configuration and begin, taken only when idle |
| cfgChain | input | 1 | 1 = follow descriptors, 0 = single block |
| cfgTagFwd | input | 1 | Push descriptor upper half before data |
| cfgIrqEn | input | 1 | Honour descriptor IRQ bit as chain end |
| cfgTagAddr | input | ADDR_W | Initial descriptor address |
| cfgDataAddr | input | ADDR_W | Initial data address |
| cfgCount | input | 16 | Initial quadword count |
| memReq | output | 1 | Memory read request, held until response |
| memAddr | output | ADDR_W | Memory read address |
| memValid | input | 1 | Memory response valid |
| memRdata | input | 128 | Memory response quadword |
| outValid | output | 1 | Beat offered to the FIFO |
| outData | output | 128 | Beat payload |
| outIsTag | output | 1 | Beat is a forwarded descriptor half |
| outReady | input | 1 | FIFO accepts the beat |
| busy | output | 1 | Channel running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unknown descriptor ID seen |
| ctrlHi | output | 16 | Bits [31:16] of the last applied descriptor |
| curCount | output | 16 | Remaining quadword count |
| curDataAddr | output | ADDR_W | Current data address |
| curTagAddr | output | ADDR_W | Current descriptor address |

## Verification
The hardest case to reach is the refused forwarded descriptor. The offer lasts a single cycle, and a refusal must send the block back to memory rather than wait. The stimulus holds `outReady` low, counts the memory responses returned for the descriptor's address until at least two reads have occurred, and then releases `outReady`. The early end from the IRQ bit is reached by running the same descriptor list twice, first with the enable off and then with it on. The CNT and NEXT address rules are shown by data beats that only land on the expected addresses if the next descriptor was fetched from the right place.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int QW_W  = 128;
  localparam int CNT_W = 16;

  typedef enum logic [2:0] {
    TAG_REFE = 3'd0,
    TAG_CNT  = 3'd1,
    TAG_NEXT = 3'd2,
    TAG_REF  = 3'd3,
    TAG_END  = 3'd7
  } tag_id_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic latchWord;
    logic latchTag;
    logic advData;
    logic applyTag;
    logic clearEnd;
    logic addrTag;
    logic selTag;
  } seq_strobe_t;

  function automatic logic idKnown(input logic [2:0] id);
    return (id == TAG_REFE) || (id == TAG_CNT) || (id == TAG_NEXT) ||
           (id == TAG_REF)  || (id == TAG_END);
  endfunction
endpackage

// File: rtl/chain_dma_dp.sv
module chain_dma_dp
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         stb,
  input  logic                cfgChain,
  input  logic                cfgIrqEn,
  input  logic [ADDR_W-1:0]   cfgTagAddr,
  input  logic [ADDR_W-1:0]   cfgDataAddr,
  input  logic [CNT_W-1:0]    cfgCount,
  input  logic [QW_W-1:0]     memRdata,
  output logic                countZero,
  output logic                endPending,
  output logic                tagKnown,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [QW_W-1:0]     outData,
  output logic [15:0]         ctrlHi,
  output logic [CNT_W-1:0]    curCount,
  output logic [ADDR_W-1:0]   curDataAddr,
  output logic [ADDR_W-1:0]   curTagAddr
);
  localparam int FIELD_LO = 32;
  localparam logic [ADDR_W-1:0] QW_STEP = ADDR_W'(16);

  logic [CNT_W-1:0]  countR;
  logic [ADDR_W-1:0] dataAddrR;
  logic [ADDR_W-1:0] tagAddrR;
  logic [15:0]       ctrlHiR;
  logic [QW_W-1:0]   wordR;
  logic [QW_W-1:0]   tagR;
  logic              endPendR;
  logic              irqEnR;

  logic [CNT_W-1:0]  tagCount;
  logic [2:0]        tagId;
  logic              tagIrq;
  logic [ADDR_W-1:0] tagField;
  logic [ADDR_W-1:0] afterTag;
  logic [ADDR_W-1:0] cntSpan;

  always_comb begin
    tagCount = tagR[CNT_W-1:0];
    tagId    = tagR[30:28];
    tagIrq   = tagR[31];
    tagField = tagR[FIELD_LO +: ADDR_W];
    afterTag = tagAddrR + QW_STEP;
    cntSpan  = ADDR_W'({tagCount, 4'b0000});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countR    <= '0;
      dataAddrR <= '0;
      tagAddrR  <= '0;
      ctrlHiR   <= '0;
      wordR     <= '0;
      tagR      <= '0;
      endPendR  <= 1'b0;
      irqEnR    <= 1'b0;
    end else begin
      if (stb.loadCfg) begin
        countR    <= cfgCount;
        dataAddrR <= cfgDataAddr;
        tagAddrR  <= cfgTagAddr;
        ctrlHiR   <= '0;
        endPendR  <= !cfgChain;
        irqEnR    <= cfgIrqEn;
      end
      if (stb.latchWord) wordR <= memRdata;
      if (stb.latchTag)  tagR  <= memRdata;
      if (stb.advData) begin
        dataAddrR <= dataAddrR + QW_STEP;
        countR    <= countR - 1'b1;
      end
      if (stb.clearEnd) endPendR <= 1'b0;
      if (stb.applyTag) begin
        countR  <= tagCount;
        ctrlHiR <= tagR[31:16];
        case (tagId)
          TAG_REFE: begin
            dataAddrR <= tagField;
            tagAddrR  <= afterTag;
            endPendR  <= 1'b1;
          end
          TAG_CNT: begin
            dataAddrR <= afterTag;
            tagAddrR  <= afterTag + cntSpan;
          end
          TAG_NEXT: begin
            dataAddrR <= afterTag;
            tagAddrR  <= tagField;
          end
          TAG_REF: begin
            dataAddrR <= tagField;
            tagAddrR  <= afterTag;
          end
          TAG_END: begin
            dataAddrR <= afterTag;
            endPendR  <= 1'b1;
          end
          default: ;
        endcase
        if (tagIrq && irqEnR) endPendR <= 1'b1;
      end
    end
  end

  assign countZero   = (countR == '0);
  assign endPending  = endPendR;
  assign tagKnown    = idKnown(tagId);
  assign memAddr     = stb.addrTag ? tagAddrR : dataAddrR;
  assign outData     = stb.selTag ? {{(QW_W-64){1'b0}}, tagR[QW_W-1:64]} : wordR;
  assign ctrlHi      = ctrlHiR;
  assign curCount    = countR;
  assign curDataAddr = dataAddrR;
  assign curTagAddr  = tagAddrR;

  // R3: the control only advances on a non-empty count
  p_adv_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.advData |-> !countZero);

  // R4: a descriptor is applied only when its ID decodes
  p_apply_known_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.applyTag |-> tagKnown);
endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cfgTagFwd,
  input  logic        memValid,
  input  logic        outReady,
  input  logic        countZero,
  input  logic        endPending,
  input  logic        tagKnown,
  output seq_strobe_t stb,
  output logic        memReq,
  output logic        outValid,
  output logic        outIsTag,
  output logic        busy,
  output logic        done,
  output logic        err
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_DREQ, ST_DSEND, ST_TREQ, ST_TSEND, ST_DECODE
  } seq_state_e;

  seq_state_e state, nextState;
  logic fwdR, doneR, errR;
  logic finish, fault;

  always_comb begin
    nextState = state;
    stb       = '0;
    memReq    = 1'b0;
    outValid  = 1'b0;
    outIsTag  = 1'b0;
    finish    = 1'b0;
    fault     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.loadCfg = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!countZero) begin
          nextState = ST_DREQ;
        end else if (endPending) begin
          stb.clearEnd = 1'b1;
          finish       = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          nextState = ST_TREQ;
        end
      end
      ST_DREQ: begin
        memReq = 1'b1;
        if (memValid) begin
          stb.latchWord = 1'b1;
          nextState     = ST_DSEND;
        end
      end
      ST_DSEND: begin
        outValid = 1'b1;
        if (outReady) begin
          stb.advData = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      ST_TREQ: begin
        memReq      = 1'b1;
        stb.addrTag = 1'b1;
        if (memValid) begin
          stb.latchTag = 1'b1;
          nextState    = fwdR ? ST_TSEND : ST_DECODE;
        end
      end
      ST_TSEND: begin
        outValid   = 1'b1;
        outIsTag   = 1'b1;
        stb.selTag = 1'b1;
        nextState  = outReady ? ST_DECODE : ST_TREQ;
      end
      ST_DECODE: begin
        if (tagKnown) begin
          stb.applyTag = 1'b1;
          nextState    = ST_CHECK;
        end else begin
          fault     = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      fwdR  <= 1'b0;
      doneR <= 1'b0;
      errR  <= 1'b0;
    end else begin
      state <= nextState;
      doneR <= finish;
      if (stb.loadCfg) begin
        fwdR <= cfgTagFwd;
        errR <= 1'b0;
      end else if (fault) begin
        errR <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneR;
  assign err  = errR;

  // R13: completion is a single-cycle pulse seen only when idle
  p_done_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_done_single_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12: a fault stops the channel without completion
  p_err_stop_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> (!busy && !done));

  // R11: a refused descriptor offer goes back to memory
  p_tag_refetch_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIsTag && !outReady) |=> (memReq && !outValid));
endmodule

// File: rtl/chain_dma_seq.sv
module chain_dma_seq
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cfgChain,
  input  logic              cfgTagFwd,
  input  logic              cfgIrqEn,
  input  logic [ADDR_W-1:0] cfgTagAddr,
  input  logic [ADDR_W-1:0] cfgDataAddr,
  input  logic [15:0]       cfgCount,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [127:0]      memRdata,
  output logic              outValid,
  output logic [127:0]      outData,
  output logic              outIsTag,
  input  logic              outReady,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [15:0]       ctrlHi,
  output logic [15:0]       curCount,
  output logic [ADDR_W-1:0] curDataAddr,
  output logic [ADDR_W-1:0] curTagAddr
);
  seq_strobe_t stb;
  logic countZero, endPending, tagKnown;

  chain_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgTagFwd(cfgTagFwd),
    .memValid(memValid), .outReady(outReady), .countZero(countZero),
    .endPending(endPending), .tagKnown(tagKnown), .stb(stb),
    .memReq(memReq), .outValid(outValid), .outIsTag(outIsTag),
    .busy(busy), .done(done), .err(err)
  );

  chain_dma_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgChain(cfgChain),
    .cfgIrqEn(cfgIrqEn), .cfgTagAddr(cfgTagAddr), .cfgDataAddr(cfgDataAddr),
    .cfgCount(cfgCount), .memRdata(memRdata), .countZero(countZero),
    .endPending(endPending), .tagKnown(tagKnown), .memAddr(memAddr),
    .outData(outData), .ctrlHi(ctrlHi), .curCount(curCount),
    .curDataAddr(curDataAddr), .curTagAddr(curTagAddr)
  );

  // R3: a waiting data beat keeps its payload
  p_hold_beat_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outIsTag && !outReady) |=> (outValid && $stable(outData)));
endmodule

// File: tb/chain_dma_seq_bench.sv
`timescale 1ns/1ps
module chain_dma_seq_bench;
  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] cnt;
    logic        alt;
  } vec_t;
  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{addr: 32'h040, cnt: 16'd3, alt: 1'b0},
    '{addr: 32'h200, cnt: 16'd5, alt: 1'b1},
    '{addr: 32'h3F0, cnt: 16'd1, alt: 1'b0},
    '{addr: 32'h080, cnt: 16'd0, alt: 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 0, cfgChain = 0, cfgTagFwd = 0, cfgIrqEn = 0;
  logic [31:0] cfgTagAddr = 0, cfgDataAddr = 0;
  logic [15:0] cfgCount = 0;
  logic memReq, memValid = 0;
  logic [31:0] memAddr;
  logic [127:0] memRdata = 0;
  logic outValid, outIsTag, outReady = 0;
  logic [127:0] outData;
  logic busy, done, err;
  logic [15:0] ctrlHi, curCount;
  logic [31:0] curDataAddr, curTagAddr;

  always #2 clk = ~clk;

  chain_dma_seq u_chain_dma_seq (.*);

  logic [127:0] mem [64];
  logic rdyAlt = 0, rdyForce = 0;
  logic [127:0] logData [16];
  logic logTag [16];
  int logN = 0, doneCnt = 0, tagReads = 0;
  logic [31:0] watchAddr = 32'hFFFF_FFFF;
  int checks = 0, failures = 0;

  always @(posedge clk) begin
    memValid <= rstN && memReq && !memValid;
    memRdata <= mem[memAddr[9:4]];
    if (outValid && outReady && logN < 16) begin
      logData[logN] <= outData;
      logTag[logN]  <= outIsTag;
      logN <= logN + 1;
    end
    if (done) doneCnt <= doneCnt + 1;
    if (memValid && memAddr == watchAddr) tagReads <= tagReads + 1;
  end

  always @(negedge clk) outReady <= rdyAlt ? ~outReady : rdyForce;

  function automatic logic [127:0] dataAt(input logic [31:0] a);
    return {32'hDA7A0000 ^ a, a, ~a, a + 32'h11};
  endfunction

  function automatic logic [127:0] mkTag(input logic [31:0] at, input logic [2:0] id,
      input logic irq, input logic [11:0] spare, input logic [15:0] cnt,
      input logic [31:0] field);
    return {32'hF00D0000, at, field, irq, id, spare, cnt};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runChan(input logic chain, input logic fwd, input logic irqEn,
      input logic [31:0] ta, input logic [31:0] da, input logic [15:0] cnt);
    int n;
    @(negedge clk);
    logN = 0; doneCnt = 0; tagReads = 0;
    cfgChain = chain; cfgTagFwd = fwd; cfgIrqEn = irqEn;
    cfgTagAddr = ta; cfgDataAddr = da; cfgCount = cnt; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 3000, "watchdog", 128'(n), 128'(3000));
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    checks++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = dataAt(32'(i * 16));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, err, outValid, memReq} == 5'b0, "R1 reset outputs",
        128'({busy, done, err, outValid, memReq}), 128'(0));
    rstN = 1;
    @(negedge clk);

    // R2 normal-mode table
    for (int v = 0; v < NV; v++) begin
      rdyAlt = VECS[v].alt; rdyForce = 1;
      runChan(0, 0, 0, 32'h0, VECS[v].addr, VECS[v].cnt);
      rdyAlt = 0;
      chk(logN == int'(VECS[v].cnt), "R2 beat count", 128'(logN), 128'(VECS[v].cnt));
      for (int b = 0; b < int'(VECS[v].cnt); b++)
        chk(logData[b] == dataAt(VECS[v].addr + 32'(b * 16)), "R2 beat data",
            logData[b], dataAt(VECS[v].addr + 32'(b * 16)));
      chk(curDataAddr == VECS[v].addr + 32'(VECS[v].cnt) * 16, "R2 final addr",
          128'(curDataAddr), 128'(VECS[v].addr + 32'(VECS[v].cnt) * 16));
      chk(doneCnt == 1 && !busy, "R13 single done pulse", 128'(doneCnt), 128'(1));
    end

    // R3 beat held while refused
    rdyForce = 0;
    @(negedge clk);
    logN = 0; doneCnt = 0;
    cfgChain = 0; cfgDataAddr = 32'h080; cfgCount = 2; start = 1;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    chk(outValid && outData == dataAt(32'h080), "R3 held beat", outData, dataAt(32'h080));
    chk(curDataAddr == 32'h080 && curCount == 2, "R3 no advance while refused",
        128'({curDataAddr, curCount}), 128'({32'h080, 16'd2}));
    rdyForce = 1;
    repeat (20) @(negedge clk);
    chk(logN == 2 && !busy, "R3 completes after ready", 128'(logN), 128'(2));

    // R4-R8 chain walk: CNT -> NEXT -> REF -> REFE
    mem[6'h10] = mkTag(32'h100, 3'd1, 0, 12'h111, 16'd2, 32'h0);
    mem[6'h13] = mkTag(32'h130, 3'd2, 0, 12'h222, 16'd1, 32'h200);
    mem[6'h20] = mkTag(32'h200, 3'd3, 0, 12'h333, 16'd1, 32'h300);
    mem[6'h21] = mkTag(32'h210, 3'd0, 0, 12'hABC, 16'd1, 32'h380);
    runChan(1, 0, 0, 32'h100, 32'h0, 16'd0);
    chk(logN == 5, "R5 chain beat count", 128'(logN), 128'(5));
    chk(logData[0] == dataAt(32'h110) && logData[1] == dataAt(32'h120),
        "R6 CNT data follows tag", logData[1], dataAt(32'h120));
    chk(logData[2] == dataAt(32'h140), "R6 CNT next tag / R7 NEXT data",
        logData[2], dataAt(32'h140));
    chk(logData[3] == dataAt(32'h300), "R7 NEXT jump / R8 REF data",
        logData[3], dataAt(32'h300));
    chk(logData[4] == dataAt(32'h380), "R8 REF continues / R5 REFE data",
        logData[4], dataAt(32'h380));
    chk(curTagAddr == 32'h220 && curDataAddr == 32'h390, "R5 REFE addresses",
        128'({curTagAddr, curDataAddr}), 128'({32'h220, 32'h390}));
    chk(ctrlHi == 16'h0ABC && curCount == 0, "R4 ctrlHi copy",
        128'(ctrlHi), 128'(16'h0ABC));
    chk(doneCnt == 1 && !err, "R5 chain done", 128'(doneCnt), 128'(1));

    // R9 / R10 IRQ handling
    mem[6'h00] = mkTag(32'h000, 3'd1, 1, 12'h0, 16'd1, 32'h0);
    mem[6'h02] = mkTag(32'h020, 3'd7, 0, 12'h0, 16'd1, 32'h0);
    runChan(1, 0, 0, 32'h000, 32'h0, 16'd0);
    chk(logN == 2 && logData[1] == dataAt(32'h030), "R10 irq ignored / R9 END data",
        logData[1], dataAt(32'h030));
    chk(doneCnt == 1, "R9 END finishes", 128'(doneCnt), 128'(1));
    runChan(1, 0, 1, 32'h000, 32'h0, 16'd0);
    chk(logN == 1 && curTagAddr == 32'h020, "R10 irq ends early",
        128'({logN, curTagAddr}), 128'({32'd1, 32'h020}));

    // R11 forwarding with refusal
    mem[6'h00] = mkTag(32'h000, 3'd7, 0, 12'h5A5, 16'd1, 32'h0);
    rdyForce = 0;
    watchAddr = 32'h000;
    @(negedge clk);
    logN = 0; doneCnt = 0; tagReads = 0;
    cfgChain = 1; cfgTagFwd = 1; cfgIrqEn = 0; cfgTagAddr = 32'h000;
    cfgCount = 0; start = 1;
    @(negedge clk);
    start = 0;
    for (int w = 0; w < 200 && tagReads < 2; w++) @(negedge clk);
    chk(tagReads >= 2 && logN == 0, "R11 refetch on refusal", 128'(tagReads), 128'(2));
    rdyForce = 1;
    repeat (30) @(negedge clk);
    chk(logN == 2 && logTag[0] && logData[0] == {64'h0, mem[0][127:64]},
        "R11 tag half first", logData[0], {64'h0, mem[0][127:64]});
    chk(!logTag[1] && logData[1] == dataAt(32'h010), "R11 data after tag",
        logData[1], dataAt(32'h010));

    // R12 unknown ID
    mem[6'h00] = mkTag(32'h000, 3'd4, 0, 12'h0, 16'd3, 32'h0);
    runChan(1, 0, 0, 32'h000, 32'h0, 16'd0);
    chk(err && !busy && doneCnt == 0 && logN == 0, "R12 unknown id",
        128'({err, busy, doneCnt[7:0], logN[7:0]}), 128'({1'b1, 1'b0, 8'd0, 8'd0}));
    runChan(0, 0, 0, 32'h0, 32'h040, 16'd1);
    chk(!err && doneCnt == 1, "R12 err cleared by start", 128'(err), 128'(0));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule